// File: doc/BRIEF.md
# Fractional-Increment Time Counter

This block keeps a free-running time-of-day value in whole nanoseconds, 64 bits wide. A 32-bit fraction of a nanosecond is carried below it. On each enabled cycle of the timing clock, the block adds a fixed-point step to the combined integer-and-fraction accumulator. The step has 32 fractional bits. A base step is held in a register. The step that is actually applied is the base times a multiplier, and a two-bit link-speed input picks that multiplier. One speed code gives a multiplier of zero, which freezes the time.

Software sees four 32-bit words through a simple register port. Reading the low time word snapshots the upper half, so a later high-word read returns the matching upper half. A time write and an increment update each take effect only when the high word arrives. Until then, the low word waits in a staging register. The block also drives the live integer time as a parallel output for timestamp consumers.

Top module: `tod_counter`

## Requirements
- R1: After reset the time and its fraction are zero. The base step is 0x0000_0001_9999_9999 (about 1.6 ns). Read data is zero.
- R2: On every rising edge with `en_i` high and no time load, the 96-bit accumulator {time, 32-bit fraction} adds the applied step. The applied step is 64 bits, with the integer part in bits 63:32. `time_o` is the integer part, which wraps modulo 2^64.
- R3: `speed_i` picks the multiplier on the base step: 0 gives x1, 1 gives x2, 2 gives x20 and 3 gives x0. The x0 case stops the time.
- R4: The applied step is a register reloaded from base times multiplier on every edge. A change of speed or of base therefore governs accumulation from the second rising edge after it.
- R5: With `en_i` low and no time load, `time_o` holds its value.
- R6: A read of address 0 returns time bits 31:0 as they stand at that edge, and captures bits 63:32 at the same edge. A later read of address 1 returns the captured upper half, not the live one. Read data appears on `reg_rdata_o` after the edge that samples the read and holds until the next read.
- R7: A write to address 0 only stages the low word. A write to address 1 loads the time with {written word, staged low word} and clears the fraction, and it overrides accumulation in that cycle.
- R8: A write to address 2 only stages the low word of the base step. A write to address 3 commits {written word, staged word} as the base step. Reads of addresses 2 and 3 return the committed base, low and high halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| speed_i | input | 2 | Link-speed code selecting the step multiplier |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Word address: 0 time low, 1 time high, 2 step low, 3 step high |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| time_o | output | 64 | Live integer nanosecond time |

## Verification
The assertions check, on every cycle, the rules that relate one edge to the next. Time holds when counting is off. The x0 speed code forces a zero applied step. A high-word time write lands in the upper half. A low-word read returns the low half seen at that edge. The time also moves on every enabled tick that has a step of at least one nanosecond. The bench's scenarios have to show the rest. These are the exact accumulated sums for each multiplier and fractional step, with carries across word boundaries and wraparound. They also include the snapshot that outlives a carry into the upper half, the staging of low words that change nothing until the high word arrives, and the two-edge delay before a speed change takes effect.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned MULT_W = 5;

  typedef enum logic [1:0] {
    ADDR_TIME_LO = 2'd0,
    ADDR_TIME_HI = 2'd1,
    ADDR_STEP_LO = 2'd2,
    ADDR_STEP_HI = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SPD_FAST = 2'd0,
    SPD_MID  = 2'd1,
    SPD_SLOW = 2'd2,
    SPD_HALT = 2'd3
  } speed_e;

  function automatic logic [MULT_W-1:0] speed_mult(speed_e s);
    case (s)
      SPD_FAST: speed_mult = MULT_W'(1);
      SPD_MID:  speed_mult = MULT_W'(2);
      SPD_SLOW: speed_mult = MULT_W'(20);
      default:  speed_mult = '0;
    endcase
  endfunction
endpackage

// File: rtl/tod_regif.sv
module tod_regif #(
  parameter int unsigned REG_W = 32,
  localparam int unsigned WIDE_W = 2 * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [WIDE_W-1:0] time_i,
  input  logic [WIDE_W-1:0] base_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              time_ld_o,
  output logic [WIDE_W-1:0] time_val_o,
  output logic              step_ld_o,
  output logic [WIDE_W-1:0] step_val_o
);
  import tod_pkg::*;

  reg_addr_e   addr;
  logic [REG_W-1:0] time_lo_q, step_lo_q, snap_hi_q, rdata_q;

  assign addr = reg_addr_e'(addr_i);

  // staged low words, committed by the high-word write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_lo_q <= '0;
      step_lo_q <= '0;
    end else if (wr_i) begin
      if (addr == ADDR_TIME_LO) time_lo_q <= wdata_i;
      if (addr == ADDR_STEP_LO) step_lo_q <= wdata_i;
    end
  end

  assign time_ld_o  = wr_i && (addr == ADDR_TIME_HI);
  assign time_val_o = {wdata_i, time_lo_q};
  assign step_ld_o  = wr_i && (addr == ADDR_STEP_HI);
  assign step_val_o = {wdata_i, step_lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      snap_hi_q <= '0;
    end else if (rd_i) begin
      case (addr)
        ADDR_TIME_LO: begin
          rdata_q   <= time_i[REG_W-1:0];
          snap_hi_q <= time_i[WIDE_W-1:REG_W];
        end
        ADDR_TIME_HI: rdata_q <= snap_hi_q;
        ADDR_STEP_LO: rdata_q <= base_i[REG_W-1:0];
        default:      rdata_q <= base_i[WIDE_W-1:REG_W];
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/tod_rate.sv
module tod_rate #(
  parameter int unsigned STEP_W = 64,
  parameter logic [STEP_W-1:0] BASE_STEP = 64'h0000_0001_9999_9999
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        speed_i,
  input  logic              ld_i,
  input  logic [STEP_W-1:0] ld_val_i,
  output logic [STEP_W-1:0] base_o,
  output logic [STEP_W-1:0] step_o
);
  import tod_pkg::*;

  localparam int unsigned PROD_W = STEP_W + MULT_W;

  logic [STEP_W-1:0] base_q, step_q;
  logic [MULT_W-1:0] mult;
  logic [PROD_W-1:0] prod;

  assign mult = speed_mult(speed_e'(speed_i));
  assign prod = PROD_W'(base_q) * PROD_W'(mult);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= BASE_STEP;
      step_q <= BASE_STEP;
    end else begin
      if (ld_i) base_q <= ld_val_i;
      // reloaded every edge so speed changes follow on the next tick
      step_q <= prod[STEP_W-1:0];
    end
  end

  assign base_o = base_q;
  assign step_o = step_q;
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned STEP_W = 64,
  localparam int unsigned ACC_W = TIME_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ld_i,
  input  logic [TIME_W-1:0] ld_val_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [TIME_W-1:0] time_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (ld_i)  acc_q <= {ld_val_i, {FRAC_W{1'b0}}};
    else if (en_i)  acc_q <= acc_q + ACC_W'(step_i);
  end

  assign time_o = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned FRAC_W = 32,
  parameter logic [2*REG_W-1:0] BASE_STEP = 64'h0000_0001_9999_9999,
  localparam int unsigned TIME_W = 2 * REG_W,
  localparam int unsigned STEP_W = 2 * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        speed_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [TIME_W-1:0] time_o
);
  logic              time_ld, step_ld;
  logic [TIME_W-1:0] time_val;
  logic [STEP_W-1:0] step_val, base_step, eff_step;

  tod_regif #(.REG_W(REG_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .time_i     (time_o),
    .base_i     (base_step),
    .rdata_o    (reg_rdata_o),
    .time_ld_o  (time_ld),
    .time_val_o (time_val),
    .step_ld_o  (step_ld),
    .step_val_o (step_val)
  );

  tod_rate #(.STEP_W(STEP_W), .BASE_STEP(BASE_STEP)) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .speed_i  (speed_i),
    .ld_i     (step_ld),
    .ld_val_i (step_val),
    .base_o   (base_step),
    .step_o   (eff_step)
  );

  tod_accum #(.TIME_W(TIME_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .ld_i     (time_ld),
    .ld_val_i (time_val),
    .step_i   (eff_step),
    .time_o   (time_o)
  );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int unsigned REG_W = 32,
  localparam int unsigned TIME_W = 2 * REG_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [1:0]        speed_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [1:0]        reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic [TIME_W-1:0] time_o,
  input logic [TIME_W-1:0] eff_step
);
  logic hi_wr;
  assign hi_wr = reg_wr_i && (reg_addr_i == 2'd1);

  // R5
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !hi_wr) |=> $stable(time_o));

  // R3
  halt_speed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_i == 2'd3) |=> (eff_step == '0));

  // R7
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr |=> (time_o[TIME_W-1:REG_W] == $past(reg_wdata_i)));

  // R6
  lo_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 2'd0) |=> (reg_rdata_o == $past(time_o[REG_W-1:0])));

  // R2
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !hi_wr && eff_step[TIME_W-1:REG_W] != '0) |=> (time_o != $past(time_o)));
endmodule

bind tod_counter tod_counter_chk #(.REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .speed_i     (speed_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .time_o      (time_o),
  .eff_step    (eff_step)
);

// File: tb/tod_counter_test.sv
`timescale 1ns/1ps
module tod_counter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  speed_i = 2'd0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [63:0] time_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  tod_counter uut (.*);

  typedef struct packed {
    logic [63:0] t0;
    logic [63:0] step;
    logic [1:0]  spd;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{64'h0,                    64'h1_0000_0000, 2'd0, 8'd10},
    '{64'h1000,                 64'h1_9999_9999, 2'd0, 8'd10},
    '{64'h0000_0000_FFFF_FFF0,  64'h1_9999_9999, 2'd1, 8'd12},
    '{64'hABCD,                 64'h1_9999_9999, 2'd2, 8'd5},
    '{64'h77,                   64'h1_9999_9999, 2'd3, 8'd20},
    '{64'hFFFF_FFFF_FFFF_FFFE,  64'h1_0000_0000, 2'd0, 8'd5},
    '{64'h0,                    64'h0_8000_0000, 2'd0, 8'd7}
  };

  function automatic logic [127:0] ref_mult(logic [1:0] s);
    case (s)
      2'd0: ref_mult = 128'd1;
      2'd1: ref_mult = 128'd2;
      2'd2: ref_mult = 128'd20;
      default: ref_mult = 128'd0;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic run(int n);
    en_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  task automatic set_time(logic [63:0] t);
    wr(2'd0, t[31:0]);
    wr(2'd1, t[63:32]);
  endtask

  task automatic set_step(logic [63:0] s);
    wr(2'd2, s[31:0]);
    wr(2'd3, s[63:32]);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] lo, hi;
    logic [127:0] prod;
    logic [63:0] exp_t;

    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 rdata", 64'(reg_rdata_o), 64'h0);
    check("R1 time_o", time_o, 64'h0);
    rd(2'd0, lo); check("R1 time lo", 64'(lo), 64'h0);
    rd(2'd1, hi); check("R1 time hi", 64'(hi), 64'h0);
    rd(2'd2, lo); check("R1 step lo", 64'(lo), 64'h9999_9999);
    rd(2'd3, hi); check("R1 step hi", 64'(hi), 64'h1);

    // R2 R3 vector table
    foreach (VEC[i]) begin
      en_i = 1'b0;
      speed_i = VEC[i].spd;
      set_step(VEC[i].step);
      set_time(VEC[i].t0);
      idle(2);
      run(int'(VEC[i].n));
      prod = 128'(VEC[i].n) * 128'(VEC[i].step) * ref_mult(VEC[i].spd);
      exp_t = VEC[i].t0 + prod[95:32];
      check($sformatf("R2/R3 vec%0d time_o", i), time_o, exp_t);
      rd(2'd0, lo);
      rd(2'd1, hi);
      check($sformatf("R2 R6 vec%0d readback", i), {hi, lo}, exp_t);
    end

    // R5 enable low holds
    speed_i = 2'd0;
    set_step(64'h1_0000_0000);
    set_time(64'h1234_5678_0000_0042);
    idle(20);
    check("R5 hold", time_o, 64'h1234_5678_0000_0042);

    // R7 low-word write alone changes nothing; high commits
    wr(2'd0, 32'hDEAD_0000);
    idle(3);
    check("R7 lo staged only", time_o, 64'h1234_5678_0000_0042);
    wr(2'd1, 32'h0000_0009);
    check("R7 hi commit", time_o, 64'h0000_0009_DEAD_0000);

    // R7 high write overrides counting and clears fraction
    set_step(64'h0_8000_0000);
    set_time(64'h0);
    idle(2);
    en_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);          // fraction now 0.5
    wr(2'd0, 32'h100);                           // counting continues
    wr(2'd1, 32'h7);                             // load wins
    check("R7 load over count", time_o, 64'h7_0000_0100);
    @(posedge clk_i); @(negedge clk_i);          // 0.5 only: no carry
    en_i = 1'b0;
    check("R7 fraction cleared", time_o, 64'h7_0000_0100);

    // R6 snapshot of upper half survives a carry
    set_step(64'h1_0000_0000);
    set_time(64'h5_FFFF_FFF0);
    idle(2);
    en_i = 1'b1;
    rd(2'd0, lo);
    idle(40);
    rd(2'd1, hi);
    en_i = 1'b0;
    check("R6 snap lo", 64'(lo), 64'hFFFF_FFF0);
    check("R6 snap hi", 64'(hi), 64'h5);
    check("R6 live hi moved", 64'(time_o[63:32]), 64'h6);

    // R8 low step word alone has no effect
    wr(2'd2, 32'h8000_0000);
    set_time(64'h0);
    idle(2);
    run(10);
    check("R8 lo staged only", time_o, 64'd10);
    rd(2'd2, lo); check("R8 base lo kept", 64'(lo), 64'h0);
    wr(2'd3, 32'h0);
    rd(2'd2, lo); check("R8 base lo", 64'(lo), 64'h8000_0000);
    rd(2'd3, hi); check("R8 base hi", 64'(hi), 64'h0);
    set_time(64'h0);
    idle(2);
    run(10);
    check("R8 new step", time_o, 64'd5);

    // R4 speed change governs from second edge
    set_step(64'h1_0000_0000);
    set_time(64'h0);
    idle(2);
    speed_i = 2'd1;
    run(3);
    check("R4 speed latency", time_o, 64'd5);

    // R3 halt code mid-run
    speed_i = 2'd3;
    run(1);                                      // old x2 step still applied
    run(15);
    check("R3 halt", time_o, 64'd7);

    finish_up();
  end
endmodule